// File: doc/BRIEF.md
# Programmable Panel Timing Generator

This block produces the raster timing for a parallel RGB thin-film panel: a pixel clock enable taken from the system clock, a line sync, a frame sync, a data-enable strobe, the raw horizontal and vertical position counters, and a single-cycle vertical-compare interrupt. All geometry comes from three packed 32-bit timing words presented on input ports. Most fields hold their value minus one. The two vertical porches hold their real line counts, so either porch can be empty.

Each line runs through sync, back porch, active pixels and front porch, counted in pixel ticks. Each frame runs through the same four phases, counted in lines. The pixel tick is the system clock divided by a 10-bit ratio field plus two. A bypass bit instead gives one tick on every system clock. Each panel output has its own polarity bit. A separate power input gates the panel outputs so that the usual enable-then-power sequence can be followed. The timing words and the interrupt phase select are captured only while the enable input is low.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset and whenever `enable` is low, `hpos`, `vpos` and `pclk_en` are 0. Each of `hsync`, `vsync`, `de` and `panel_clk` sits at its inactive level, which is 0 or 1 when its polarity bit is set.
- R2: `tim_h`, `tim_v`, `tim_clk` and `vcmp_sel` are captured on every clock while `enable` is low and are held while it is high. A change while enabled has no effect.
- R3: The divisor is `{tim_clk[31:27], tim_clk[4:0]}`. With `tim_clk[26]` = 0, `pclk_en` pulses for one cycle in every divisor+2 cycles, starting divisor+1 cycles after `enable` rises. With `tim_clk[26]` = 1, it is high on every enabled cycle.
- R4: A line spans `tim_h[15:8]`+1 sync ticks, then `tim_h[31:24]`+1 back-porch ticks, then 16·(`tim_h[7:2]`+1) active ticks, then `tim_h[23:16]`+1 front-porch ticks. `hpos` counts ticks from 0 at the start of sync. `hsync` is active during the sync span, one cycle after the position.
- R5: A frame spans `tim_v[15:10]`+1 sync lines, `tim_v[31:24]` back-porch lines, `tim_v[9:0]`+1 active lines and `tim_v[23:16]` front-porch lines. `vpos` advances on the tick that wraps `hpos`, and `vsync` is active during the sync lines.
- R6: `de` is active, one cycle after the position, only when the pixel is in both the horizontal and the vertical active spans.
- R7: Polarity bits in `tim_clk`: bit 11 inverts `vsync`, bit 12 inverts `hsync`, bit 13 inverts `panel_clk` and bit 14 inverts `de`.
- R8: While `power` is low, the four panel outputs stay at their inactive levels and the counters keep running. `power` has no effect while `enable` is low.
- R9: `vcmp_sel` picks the boundary line: 0 is the start of frame sync, 1 the start of back porch, 2 the first active line and 3 the start of front porch. `vcmp_irq` is high for one cycle after the pixel tick at pixel 0 of that line. The first frame after enable is included, and `power` does not gate it.
- R10: With an empty back porch, select 1 fires on the first active line. With an empty front porch, select 3 never fires.
- R11: Before inversion, `panel_clk` is high during the second half of each divided period, that is divider phase ≥ (divisor+2)/2. It is constantly high in bypass. It is low while disabled or unpowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Runs the timing; low holds counters at zero and opens configuration capture |
| power | input | 1 | Gates the panel outputs |
| vcmp_sel | input | 2 | Frame phase for the vertical-compare interrupt |
| tim_h | input | 32 | Horizontal timing word |
| tim_v | input | 32 | Vertical timing word |
| tim_clk | input | 32 | Divisor, bypass and polarity word |
| pclk_en | output | 1 | Pixel tick, one system clock wide |
| panel_clk | output | 1 | Panel clock level |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| hpos | output | HPOS_W | Horizontal position in ticks since line start |
| vpos | output | VPOS_W | Line number since frame start |
| vcmp_irq | output | 1 | One-cycle vertical-compare pulse |

## Verification
On every cycle, the assertions check several properties. Configuration stays frozen while enabled. Divider ticks never fall on adjacent cycles unless bypass is set. The horizontal position holds between ticks and stays below the line length. The line counter only moves on the last pixel of a line. Data enable never overlaps line sync, and the interrupt never lasts two cycles. The exact span lengths, the boundary picked by each select value, the polarity levels, the power gating, and the empty-porch cases of the interrupt can only be shown by the bench. It runs a cycle-accurate reference model through scenarios that cover each of these.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  // width of the split divisor field
  localparam int DIVF_W = 10;

  // frame phase that triggers the vertical-compare pulse
  typedef enum logic [1:0] {
    VPH_SYNC   = 2'd0,
    VPH_BACK   = 2'd1,
    VPH_ACTIVE = 2'd2,
    VPH_FRONT  = 2'd3
  } lcdt_vph_e;

  // decoded timing configuration, held while running
  typedef struct packed {
    logic [5:0]        ppl16_m1;
    logic [7:0]        hsw_m1;
    logic [7:0]        hbp_m1;
    logic [7:0]        hfp_m1;
    logic [9:0]        lpp_m1;
    logic [5:0]        vsw_m1;
    logic [7:0]        vbp;
    logic [7:0]        vfp;
    logic [DIVF_W-1:0] div;
    logic              bypass;
    logic              inv_vs;
    logic              inv_hs;
    logic              inv_pc;
    logic              inv_de;
    lcdt_vph_e         vsel;
  } lcdt_cfg_t;

endpackage

// File: rtl/lcdt_pclk.sv
module lcdt_pclk #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bypass,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             phase_hi
);

  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] ratio;
  logic [CW-1:0] ratio_m1;

  assign ratio    = {1'b0, div} + CW'(2);
  assign ratio_m1 = {1'b0, div} + CW'(1);

  assign tick     = enable && (bypass || (cnt_q == ratio_m1));
  assign phase_hi = bypass || (cnt_q >= (ratio >> 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!enable || bypass || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bypass) |=> !tick); // R3

endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         step,
  input  logic [W-1:0] len_sync,
  input  logic [W-1:0] len_back,
  input  logic [W-1:0] len_act,
  input  logic [W-1:0] len_front,
  output logic [W-1:0] pos,
  output logic [W-1:0] total,
  output logic         wrap,
  output logic         in_sync,
  output logic         in_act,
  output logic [W-1:0] b_back,
  output logic [W-1:0] b_act,
  output logic [W-1:0] b_front
);

  logic [W-1:0] pos_q, pos_d;

  assign b_back  = len_sync;
  assign b_act   = len_sync + len_back;
  assign b_front = b_act + len_act;
  assign total   = b_front + len_front;

  assign wrap    = step && (pos_q == total - W'(1));
  assign in_sync = pos_q < b_back;
  assign in_act  = (pos_q >= b_act) && (pos_q < b_front);
  assign pos     = pos_q;

  always_comb begin
    pos_d = pos_q;
    if (!enable) begin
      pos_d = '0;
    end else if (step) begin
      if (wrap) begin
        pos_d = '0;
      end else begin
        pos_d = pos_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_d;
    end
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < total); // R4
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$past(step)) |-> $stable(pos_q)); // R4

endmodule

// File: rtl/lcdt_outreg.sv
module lcdt_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic drive,
  input  logic h_sync,
  input  logic v_sync,
  input  logic h_act,
  input  logic v_act,
  input  logic clk_hi,
  input  logic irq_raw,
  input  logic inv_hs,
  input  logic inv_vs,
  input  logic inv_pc,
  input  logic inv_de,
  output logic hsync,
  output logic vsync,
  output logic de,
  output logic panel_clk,
  output logic irq
);

  logic hs_raw, vs_raw, de_raw, pc_raw;
  logic hs_d, vs_d, de_d, pc_d, irq_d;
  logic hs_q, vs_q, de_q, pc_q, irq_q;

  assign hs_raw = drive && h_sync;
  assign vs_raw = drive && v_sync;
  assign de_raw = drive && h_act && v_act;
  assign pc_raw = drive && clk_hi;

  always_comb begin
    hs_d  = hs_raw ^ inv_hs;
    vs_d  = vs_raw ^ inv_vs;
    de_d  = de_raw ^ inv_de;
    pc_d  = pc_raw ^ inv_pc;
    irq_d = irq_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      de_q  <= 1'b0;
      pc_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      hs_q  <= hs_d;
      vs_q  <= vs_d;
      de_q  <= de_d;
      pc_q  <= pc_d;
      irq_q <= irq_d;
    end
  end

  assign hsync     = hs_q;
  assign vsync     = vs_q;
  assign de        = de_q;
  assign panel_clk = pc_q;
  assign irq       = irq_q;

  AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    h_act |-> !h_sync); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R9

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int HPOS_W = 12,  // at least 11 for the widest line
  parameter int VPOS_W = 12   // at least 11 for the tallest frame
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              power,
  input  logic [1:0]        vcmp_sel,
  input  logic [31:0]       tim_h,
  input  logic [31:0]       tim_v,
  input  logic [31:0]       tim_clk,
  output logic              pclk_en,
  output logic              panel_clk,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [HPOS_W-1:0] hpos,
  output logic [VPOS_W-1:0] vpos,
  output logic              vcmp_irq
);
  import lcdt_pkg::*;

  localparam int DIV_W = DIVF_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // configuration decode and capture
  lcdt_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d.ppl16_m1 = tim_h[7:2];
    cfg_d.hsw_m1   = tim_h[15:8];
    cfg_d.hfp_m1   = tim_h[23:16];
    cfg_d.hbp_m1   = tim_h[31:24];
    cfg_d.lpp_m1   = tim_v[9:0];
    cfg_d.vsw_m1   = tim_v[15:10];
    cfg_d.vfp      = tim_v[23:16];
    cfg_d.vbp      = tim_v[31:24];
    cfg_d.div      = {tim_clk[31:27], tim_clk[4:0]};
    cfg_d.bypass   = tim_clk[26];
    cfg_d.inv_vs   = tim_clk[11];
    cfg_d.inv_hs   = tim_clk[12];
    cfg_d.inv_pc   = tim_clk[13];
    cfg_d.inv_de   = tim_clk[14];
    cfg_d.vsel     = lcdt_vph_e'(vcmp_sel);
  end

  logic unused_fields;
  assign unused_fields = ^{tim_h[1:0], tim_clk[25:15], tim_clk[10:5]};

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q <= '0;
    end else if (!enable) begin
      cfg_q <= cfg_d;
    end
  end

  // span lengths
  logic [HPOS_W-1:0] h_len_sync, h_len_back, h_len_act, h_len_front;
  logic [VPOS_W-1:0] v_len_sync, v_len_back, v_len_act, v_len_front;

  assign h_len_sync  = HPOS_W'(cfg_q.hsw_m1) + HPOS_W'(1);
  assign h_len_back  = HPOS_W'(cfg_q.hbp_m1) + HPOS_W'(1);
  assign h_len_act   = HPOS_W'({cfg_q.ppl16_m1, 4'b0000}) + HPOS_W'(16);
  assign h_len_front = HPOS_W'(cfg_q.hfp_m1) + HPOS_W'(1);
  assign v_len_sync  = VPOS_W'(cfg_q.vsw_m1) + VPOS_W'(1);
  assign v_len_back  = VPOS_W'(cfg_q.vbp);
  assign v_len_act   = VPOS_W'(cfg_q.lpp_m1) + VPOS_W'(1);
  assign v_len_front = VPOS_W'(cfg_q.vfp);

  // pixel tick
  logic tick, clk_hi;

  lcdt_pclk #(.DIV_W(DIV_W)) u_pclk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enable   (enable),
    .bypass   (cfg_q.bypass),
    .div      (cfg_q.div),
    .tick     (tick),
    .phase_hi (clk_hi)
  );

  // horizontal and vertical counters
  logic [HPOS_W-1:0] h_pos, h_total, h_b_back, h_b_act, h_b_front;
  logic [VPOS_W-1:0] v_pos, v_total, v_b_back, v_b_act, v_b_front;
  logic              h_wrap, h_sync, h_act;
  logic              v_wrap, v_sync, v_act;
  logic              v_step;

  lcdt_axis #(.W(HPOS_W)) u_haxis (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .enable    (enable),
    .step      (tick),
    .len_sync  (h_len_sync),
    .len_back  (h_len_back),
    .len_act   (h_len_act),
    .len_front (h_len_front),
    .pos       (h_pos),
    .total     (h_total),
    .wrap      (h_wrap),
    .in_sync   (h_sync),
    .in_act    (h_act),
    .b_back    (h_b_back),
    .b_act     (h_b_act),
    .b_front   (h_b_front)
  );

  assign v_step = h_wrap;

  lcdt_axis #(.W(VPOS_W)) u_vaxis (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .enable    (enable),
    .step      (v_step),
    .len_sync  (v_len_sync),
    .len_back  (v_len_back),
    .len_act   (v_len_act),
    .len_front (v_len_front),
    .pos       (v_pos),
    .total     (v_total),
    .wrap      (v_wrap),
    .in_sync   (v_sync),
    .in_act    (v_act),
    .b_back    (v_b_back),
    .b_act     (v_b_act),
    .b_front   (v_b_front)
  );

  logic unused_axis;
  assign unused_axis = ^{h_b_back, h_b_act, h_b_front, v_total, v_wrap};

  // vertical-compare boundary
  logic [VPOS_W-1:0] v_bnd;
  logic              irq_raw;

  always_comb begin
    case (cfg_q.vsel)
      VPH_SYNC:   v_bnd = '0;
      VPH_BACK:   v_bnd = v_b_back;
      VPH_ACTIVE: v_bnd = v_b_act;
      default:    v_bnd = v_b_front;
    endcase
  end

  assign irq_raw = tick && (h_pos == '0) && (v_pos == v_bnd);

  lcdt_outreg u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .drive     (enable && power),
    .h_sync    (h_sync),
    .v_sync    (v_sync),
    .h_act     (h_act),
    .v_act     (v_act),
    .clk_hi    (clk_hi),
    .irq_raw   (irq_raw),
    .inv_hs    (cfg_q.inv_hs),
    .inv_vs    (cfg_q.inv_vs),
    .inv_pc    (cfg_q.inv_pc),
    .inv_de    (cfg_q.inv_de),
    .hsync     (hsync),
    .vsync     (vsync),
    .de        (de),
    .panel_clk (panel_clk),
    .irq       (vcmp_irq)
  );

  assign pclk_en = tick;
  assign hpos    = h_pos;
  assign vpos    = v_pos;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (enable && $past(enable)) |-> $stable(cfg_q)); // R2
  AST_VPOS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (enable && $past(enable) && (v_pos != $past(v_pos)))
      |-> ($past(h_pos) == $past(h_total) - HPOS_W'(1))); // R5

endmodule

// File: tb/sim_lcd_timing_gen.sv
`timescale 1ns/1ps
module sim_lcd_timing_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, power;
  logic [1:0]  vcmp_sel;
  logic [31:0] tim_h, tim_v, tim_clk;
  logic        pclk_en, panel_clk, hsync, vsync, de, vcmp_irq;
  logic [11:0] hpos, vpos;

  always #2 clk = ~clk;

  lcd_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .power(power),
    .vcmp_sel(vcmp_sel), .tim_h(tim_h), .tim_v(tim_v), .tim_clk(tim_clk),
    .pclk_en(pclk_en), .panel_clk(panel_clk), .hsync(hsync), .vsync(vsync),
    .de(de), .hpos(hpos), .vpos(vpos), .vcmp_irq(vcmp_irq)
  );

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  int cnt_de, cnt_irq, cnt_tick, cnt_hs;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_hsw, m_hbp, m_ppl, m_hfp, m_vsw, m_vbp, m_lpp, m_vfp, m_ratio, m_sel;
  bit m_byp, m_ivs, m_ihs, m_ipc, m_ide;
  int m_div, m_h, m_v;
  bit e_hs, e_vs, e_de, e_pc, e_irq;

  task automatic cap(input logic [31:0] h, input logic [31:0] v,
                     input logic [31:0] c, input logic [1:0] s);
    m_hsw   = int'(h[15:8]) + 1;
    m_hfp   = int'(h[23:16]) + 1;
    m_hbp   = int'(h[31:24]) + 1;
    m_ppl   = 16 * (int'(h[7:2]) + 1);
    m_vsw   = int'(v[15:10]) + 1;
    m_lpp   = int'(v[9:0]) + 1;
    m_vfp   = int'(v[23:16]);
    m_vbp   = int'(v[31:24]);
    m_ratio = int'({c[31:27], c[4:0]}) + 2;
    m_byp   = c[26];
    m_ivs   = c[11];
    m_ihs   = c[12];
    m_ipc   = c[13];
    m_ide   = c[14];
    m_sel   = int'(s);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      cap(32'd0, 32'd0, 32'd0, 2'd0);
      m_div = 0; m_h = 0; m_v = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_pc = 0; e_irq = 0;
    end else begin
      int htot, vtot, bnd;
      bit tk, act;
      htot = m_hsw + m_hbp + m_ppl + m_hfp;
      vtot = m_vsw + m_vbp + m_lpp + m_vfp;
      tk   = enable && (m_byp || m_div == m_ratio - 1);
      act  = enable && power;
      e_hs = (act && m_h < m_hsw) ^ m_ihs;
      e_vs = (act && m_v < m_vsw) ^ m_ivs;
      e_de = (act && m_h >= m_hsw + m_hbp && m_h < m_hsw + m_hbp + m_ppl
                  && m_v >= m_vsw + m_vbp && m_v < m_vsw + m_vbp + m_lpp) ^ m_ide;
      e_pc = (act && (m_byp || m_div >= m_ratio / 2)) ^ m_ipc;
      case (m_sel)
        0: bnd = 0;
        1: bnd = m_vsw;
        2: bnd = m_vsw + m_vbp;
        default: bnd = m_vsw + m_vbp + m_lpp;
      endcase
      e_irq = tk && m_h == 0 && m_v == bnd;
      if (!enable) begin
        m_div = 0; m_h = 0; m_v = 0;
        cap(tim_h, tim_v, tim_clk, vcmp_sel);
      end else begin
        if (tk) begin
          if (m_h == htot - 1) begin
            m_h = 0;
            m_v = (m_v == vtot - 1) ? 0 : m_v + 1;
          end else begin
            m_h = m_h + 1;
          end
        end
        m_div = (m_byp || tk) ? 0 : m_div + 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      bit e_tick;
      e_tick = enable && (m_byp || m_div == m_ratio - 1);
      chk(pclk_en === e_tick,   "R3 pclk_en",   pclk_en, e_tick);
      chk(hpos == 12'(m_h),     "R4 hpos",      hpos, m_h);
      chk(vpos == 12'(m_v),     "R5 vpos",      vpos, m_v);
      chk(hsync === e_hs,       "R4/R7 hsync",  hsync, e_hs);
      chk(vsync === e_vs,       "R5/R7 vsync",  vsync, e_vs);
      chk(de === e_de,          "R6/R7 de",     de, e_de);
      chk(panel_clk === e_pc,   "R11 panel_clk", panel_clk, e_pc);
      chk(vcmp_irq === e_irq,   "R9 vcmp_irq",  vcmp_irq, e_irq);
      if (de) cnt_de++;
      if (vcmp_irq) cnt_irq++;
      if (pclk_en) cnt_tick++;
      if (hsync) cnt_hs++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr();
    cnt_de = 0; cnt_irq = 0; cnt_tick = 0; cnt_hs = 0;
  endtask

  function automatic logic [31:0] mk_h(input int sw, input int bp, input int act16, input int fp);
    return {8'(bp - 1), 8'(fp - 1), 8'(sw - 1), 6'(act16 - 1), 2'b00};
  endfunction

  function automatic logic [31:0] mk_v(input int sw, input int bp, input int lines, input int fp);
    return {8'(bp), 8'(fp), 6'(sw - 1), 10'(lines - 1)};
  endfunction

  function automatic logic [31:0] mk_c(input int dv, input bit byp, input bit ide,
                                       input bit ipc, input bit ihs, input bit ivs);
    logic [31:0] w;
    logic [9:0]  d;
    d = 10'(dv);
    w = '0;
    w[31:27] = d[9:5];
    w[4:0]   = d[4:0];
    w[26] = byp; w[14] = ide; w[13] = ipc; w[12] = ihs; w[11] = ivs;
    return w;
  endfunction

  task automatic turn_off();
    power = 0;
    step(1);
    enable = 0;
    step(2);
  endtask

  task automatic turn_on();
    enable = 1;
    power  = 1;
  endtask

  initial begin
    rst_n = 0; enable = 0; power = 0; vcmp_sel = 0;
    tim_h = 0; tim_v = 0; tim_clk = 0;
    clr();
    step(5);
    rst_n = 1;
    step(4);
    // R1: reset state
    chk(hpos == 0 && vpos == 0, "R1 counters after reset", int'(hpos) + int'(vpos), 0);
    chk(!hsync && !vsync && !de && !panel_clk, "R1 outputs after reset",
        int'({hsync, vsync, de, panel_clk}), 0);
    chk(!pclk_en && !vcmp_irq, "R1 tick/irq after reset", int'({pclk_en, vcmp_irq}), 0);
    chk_on = 1;

    // config A: line 23 ticks, frame 8 lines, ratio 2
    tim_h = mk_h(2, 3, 1, 2);
    tim_v = mk_v(2, 2, 3, 1);
    tim_clk = mk_c(0, 0, 0, 0, 0, 0);
    vcmp_sel = 2;
    // R8: power while disabled has no effect
    power = 1;
    step(1);
    clr();
    step(10);
    chk(cnt_hs == 0 && cnt_de == 0, "R8 power ignored while disabled", cnt_hs + cnt_de, 0);
    chk(hpos == 0 && cnt_tick == 0, "R1 counters held while disabled", cnt_tick, 0);
    power = 0;
    step(1);

    turn_on();
    clr();
    step(736);
    chk(cnt_de == 192,   "R6 data-enable cycles in two frames", cnt_de, 192);
    chk(cnt_irq == 2,    "R9 active-start interrupts in two frames", cnt_irq, 2);
    chk(cnt_tick == 368, "R3 ticks at ratio 2", cnt_tick, 368);

    // R2: words change while running; the old timing must persist
    tim_h = mk_h(5, 5, 2, 5);
    tim_v = mk_v(1, 0, 1, 0);
    vcmp_sel = 0;
    clr();
    step(736);
    chk(cnt_de == 192, "R2 geometry unchanged while enabled", cnt_de, 192);
    chk(cnt_irq == 2,  "R2 interrupt phase unchanged while enabled", cnt_irq, 2);

    // R8: enabled but unpowered
    power = 0;
    clr();
    step(368);
    chk(cnt_de == 0 && cnt_hs == 0, "R8 outputs inactive without power", cnt_de + cnt_hs, 0);
    chk(cnt_tick == 184, "R8 counters still run without power", cnt_tick, 184);
    turn_off();

    // R7/R1: all inversions, bypass, sync-start interrupt
    tim_h = mk_h(2, 3, 1, 2);
    tim_v = mk_v(2, 2, 3, 1);
    tim_clk = mk_c(0, 1, 1, 1, 1, 1);
    vcmp_sel = 0;
    step(2);
    chk(hsync && vsync && de && panel_clk, "R7 inactive levels inverted while disabled",
        int'({hsync, vsync, de, panel_clk}), 15);
    turn_on();
    clr();
    step(184);
    chk(cnt_tick == 184, "R3 bypass ticks every cycle", cnt_tick, 184);
    chk(cnt_irq == 1,    "R9 sync-start interrupt per frame", cnt_irq, 1);
    chk(cnt_de == 184 - 48, "R7 inverted data enable", cnt_de, 136);
    turn_off();

    // R10: empty back porch, select 1
    tim_v = mk_v(1, 0, 2, 0);
    tim_clk = mk_c(0, 1, 0, 0, 0, 0);
    vcmp_sel = 1;
    step(1);
    turn_on();
    clr();
    step(138);
    chk(cnt_irq == 2, "R10 empty back porch fires at first active line", cnt_irq, 2);
    turn_off();

    // R10: empty front porch, select 3
    vcmp_sel = 3;
    step(1);
    turn_on();
    clr();
    step(138);
    chk(cnt_irq == 0, "R10 empty front porch never fires", cnt_irq, 0);
    turn_off();

    // R3/R11: divisor using both halves of the split field (33 -> ratio 35)
    tim_v = mk_v(2, 2, 3, 1);
    tim_clk = mk_c(33, 0, 0, 0, 0, 0);
    vcmp_sel = 2;
    step(1);
    turn_on();
    clr();
    step(700);
    chk(cnt_tick == 20, "R3 split divisor ratio 35", cnt_tick, 20);
    turn_off();
    // R1: back to idle
    chk(hpos == 0 && vpos == 0 && !pclk_en, "R1 idle after disable", int'(hpos) + int'(vpos), 0);

    chk_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule